// File: doc/BRIEF.md
# Fetch Stall Sequencer

This block is the control sequencer of a single-issue, in-order processor that handles one instruction at a time. In the Running state it issues one aligned 4-byte fetch each cycle. When the instruction cache reports a hit, the returned word executes in that same cycle. A fetch miss parks the sequencer until a completion strobe arrives. The sequencer then spends one cycle executing the word it already captured, without fetching it again, and goes back to Running. A data access that misses, made by an instruction that executed cleanly, parks the sequencer in a data-wait state until its completion strobe.

Software control arrives as three pulses: activate, suspend and switch-out. Switch-out parks the sequencer permanently until reset, and completions that arrive while it is parked are dropped without any effect. The block keeps the program counter and the next program counter. It counts instruction-side and data-side stall cycles, retired instructions and retired loads. It reports the opcode and register fields of each executed word, raises a trap on a faulting instruction and pulses an error flag on illegal requests. The datapath, the caches and address translation sit outside the block.

Top module: `stall_sequencer`

## Requirements
- R1: After reset the state code is 0 (idle) and the program counter equals RESET_PC. The next program counter equals RESET_PC+4. All four counters read zero, and neither fetch nor execute is asserted.
- R2: Activate in idle moves the state to code 1 (running) on the next cycle. Suspend in running moves the state to code 0 on the next cycle and blocks fetch and execute in that cycle.
- R3: In running, with no suspend or switch-out present, fetch valid is high. The fetch address is the program counter with bits 1:0 forced to zero, and the fetch size is 4.
- R4: A fetch that misses captures the word, executes nothing and enters code 2. A completion in code 2 adds (completion cycle minus miss cycle) to the instruction stall counter and enters code 3.
- R5: In code 3 no fetch is issued. The captured word executes and the state returns to code 1, or goes to code 4 when a data miss occurs.
- R6: A fault-free executed instruction that makes a data access which misses enters code 4. A completion in code 4 adds the elapsed cycles to the data stall counter and returns to code 1.
- R7: Switch-out in any state enters code 5 on the next cycle and blocks fetch and execute in that cycle. In code 5 completions change no counter and no state, and raise no error.
- R8: A fault-free executed instruction loads the program counter with the next program counter and adds 4 to the next program counter. A faulting one raises trap and leaves both unchanged.
- R9: While execute is high, the opcode output is bits 31:26 of the executing word and the ra output is bits 25:21.
- R10: Error pulses one cycle after any of these: activate outside code 0, suspend outside code 1, or a completion outside codes 2, 4 and 5. The illegal request itself does not change the state.
- R11: The retired counter increments once for each fault-free executed instruction. The load counter increments when such an instruction also has the load flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | Activate request pulse |
| susp_i | input | 1 | Suspend, halt or deallocate request pulse |
| swout_i | input | 1 | Switch-out request pulse |
| fetch_miss_i | input | 1 | Instruction cache miss for the current fetch |
| insn_i | input | 32 | Instruction word returned for the current fetch |
| fault_i | input | 1 | The executing instruction faults |
| mem_op_i | input | 1 | The executing instruction accesses data memory |
| load_op_i | input | 1 | The executing instruction is a load |
| mem_miss_i | input | 1 | The data access missed |
| fill_done_i | input | 1 | Miss completion strobe |
| fetch_vld_o | output | 1 | Fetch request |
| fetch_addr_o | output | AW | Word-aligned fetch address |
| fetch_size_o | output | 3 | Fetch size in bytes (4) |
| exec_o | output | 1 | An instruction executes this cycle |
| opcode_o | output | 6 | Opcode field of the executing word |
| ra_o | output | 5 | ra field of the executing word |
| trap_o | output | 1 | The executing instruction faulted |
| pc_o | output | AW | Program counter |
| npc_o | output | AW | Next program counter |
| ifill_cyc_o | output | CNT_W | Instruction-side stall cycles |
| dfill_cyc_o | output | CNT_W | Data-side stall cycles |
| retired_o | output | CNT_W | Retired instruction count |
| loads_o | output | CNT_W | Retired load count |
| seq_state_o | output | 3 | State code |
| err_o | output | 1 | Illegal request or completion, one cycle late |

## Verification
A wrong state code shows up at the ports in the same cycle. In every state except idle, fetch valid and execute depend only on the state and the current requests. A reference model that compares both every cycle therefore catches the fault at once. A mistake in the stall-start mark or the elapsed arithmetic shows up only at the completion that ends the stall. Its effect on the program counter shows in the cycle after the next executed instruction. Dropped or duplicated completions show up either as an early or late move into the resume state or as an error pulse one cycle later.

// File: rtl/stseq_pkg.sv
package stseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_IWAIT   = 3'd2,
        ST_IRESUME = 3'd3,
        ST_DWAIT   = 3'd4,
        ST_PARKED  = 3'd5
    } seq_state_e;

    localparam int unsigned INSN_W     = 32;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned OPC_HI     = 31;
    localparam int unsigned OPC_LO     = 26;
    localparam int unsigned RA_HI      = 25;
    localparam int unsigned RA_LO      = 21;

    typedef struct packed {
        seq_state_e st;
        logic       err;
    } ctrl_regs_t;
endpackage

// File: rtl/stseq_ctrl.sv
module stseq_ctrl
    import stseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_i,
    input  logic       susp_i,
    input  logic       swout_i,
    input  logic       fetch_miss_i,
    input  logic       fault_i,
    input  logic       mem_op_i,
    input  logic       load_op_i,
    input  logic       mem_miss_i,
    input  logic       fill_done_i,
    output seq_state_e state_o,
    output logic       fetch_vld_o,
    output logic       exec_o,
    output logic       use_held_o,
    output logic       trap_o,
    output logic       retire_o,
    output logic       load_ret_o,
    output logic       imiss_o,
    output logic       dmiss_o,
    output logic       idone_o,
    output logic       ddone_o,
    output logic       err_o
);
    ctrl_regs_t q, d;

    always_comb begin
        fetch_vld_o = (q.st == ST_RUN) && !swout_i && !susp_i;
        exec_o      = (fetch_vld_o && !fetch_miss_i) ||
                      ((q.st == ST_IRESUME) && !swout_i);
        use_held_o  = (q.st == ST_IRESUME);
        trap_o      = exec_o && fault_i;
        retire_o    = exec_o && !fault_i;
        load_ret_o  = retire_o && load_op_i;
        imiss_o     = fetch_vld_o && fetch_miss_i;
        dmiss_o     = retire_o && mem_op_i && mem_miss_i;
        idone_o     = (q.st == ST_IWAIT) && fill_done_i && !swout_i;
        ddone_o     = (q.st == ST_DWAIT) && fill_done_i && !swout_i;

        d     = q;
        d.err = (act_i && (q.st != ST_IDLE)) ||
                (susp_i && (q.st != ST_RUN)) ||
                (fill_done_i && (q.st != ST_IWAIT) &&
                 (q.st != ST_DWAIT) && (q.st != ST_PARKED));

        unique case (q.st)
            ST_IDLE: begin
                if (act_i) d.st = ST_RUN;
            end
            ST_RUN: begin
                if (susp_i)       d.st = ST_IDLE;
                else if (imiss_o) d.st = ST_IWAIT;
                else if (dmiss_o) d.st = ST_DWAIT;
            end
            ST_IWAIT: begin
                if (idone_o) d.st = ST_IRESUME;
            end
            ST_IRESUME: begin
                d.st = dmiss_o ? ST_DWAIT : ST_RUN;
            end
            ST_DWAIT: begin
                if (ddone_o) d.st = ST_RUN;
            end
            default: d.st = ST_PARKED;
        endcase

        if (swout_i) d.st = ST_PARKED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;
    assign err_o   = q.err;
endmodule

// File: rtl/stseq_pc.sv
module stseq_pc
    import stseq_pkg::*;
#(
    parameter int unsigned    AW       = 32,
    parameter logic [AW-1:0]  RESET_PC = AW'('h100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic              capture_i,
    input  logic              use_held_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [AW-1:0]     pc_o,
    output logic [AW-1:0]     npc_o,
    output logic [AW-1:0]     fetch_addr_o,
    output logic [5:0]        opcode_o,
    output logic [4:0]        ra_o
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    typedef struct packed {
        logic [AW-1:0]     pc;
        logic [AW-1:0]     npc;
        logic [INSN_W-1:0] held;
    } pc_regs_t;

    pc_regs_t q, d;
    logic [INSN_W-1:0] cur_word;

    always_comb begin
        d = q;
        if (advance_i) begin
            d.pc  = q.npc;
            d.npc = q.npc + STEP;
        end
        if (capture_i) d.held = insn_i;
        cur_word = use_held_i ? q.held : insn_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pc   <= RESET_PC;
            q.npc  <= RESET_PC + STEP;
            q.held <= '0;
        end else begin
            q <= d;
        end
    end

    assign pc_o         = q.pc;
    assign npc_o        = q.npc;
    assign fetch_addr_o = {q.pc[AW-1:2], 2'b00};
    assign opcode_o     = cur_word[OPC_HI:OPC_LO];
    assign ra_o         = cur_word[RA_HI:RA_LO];
endmodule

// File: rtl/stseq_perf.sv
module stseq_perf #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imiss_i,
    input  logic             dmiss_i,
    input  logic             idone_i,
    input  logic             ddone_i,
    input  logic             retire_i,
    input  logic             load_ret_i,
    output logic [CNT_W-1:0] ifill_o,
    output logic [CNT_W-1:0] dfill_o,
    output logic [CNT_W-1:0] retired_o,
    output logic [CNT_W-1:0] loads_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] mark;
        logic [CNT_W-1:0] ifill;
        logic [CNT_W-1:0] dfill;
        logic [CNT_W-1:0] ret;
        logic [CNT_W-1:0] lds;
    } perf_regs_t;

    perf_regs_t q, d;
    logic [CNT_W-1:0] elapsed;

    always_comb begin
        d       = q;
        elapsed = q.cyc - q.mark;
        d.cyc   = q.cyc + 1'b1;
        if (imiss_i || dmiss_i) d.mark = q.cyc;
        if (idone_i) d.ifill = q.ifill + elapsed;
        if (ddone_i) d.dfill = q.dfill + elapsed;
        if (retire_i) d.ret = q.ret + 1'b1;
        if (load_ret_i) d.lds = q.lds + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ifill_o   = q.ifill;
    assign dfill_o   = q.dfill;
    assign retired_o = q.ret;
    assign loads_o   = q.lds;
endmodule

// File: rtl/stall_sequencer.sv
module stall_sequencer
    import stseq_pkg::*;
#(
    parameter int unsigned   AW       = 32,
    parameter int unsigned   CNT_W    = 32,
    parameter logic [AW-1:0] RESET_PC = AW'('h100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             susp_i,
    input  logic             swout_i,
    input  logic             fetch_miss_i,
    input  logic [31:0]      insn_i,
    input  logic             fault_i,
    input  logic             mem_op_i,
    input  logic             load_op_i,
    input  logic             mem_miss_i,
    input  logic             fill_done_i,
    output logic             fetch_vld_o,
    output logic [AW-1:0]    fetch_addr_o,
    output logic [2:0]       fetch_size_o,
    output logic             exec_o,
    output logic [5:0]       opcode_o,
    output logic [4:0]       ra_o,
    output logic             trap_o,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    npc_o,
    output logic [CNT_W-1:0] ifill_cyc_o,
    output logic [CNT_W-1:0] dfill_cyc_o,
    output logic [CNT_W-1:0] retired_o,
    output logic [CNT_W-1:0] loads_o,
    output logic [2:0]       seq_state_o,
    output logic             err_o
);
    seq_state_e st;
    logic use_held, retire, load_ret, imiss, dmiss, idone, ddone;

    stseq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (act_i),
        .susp_i       (susp_i),
        .swout_i      (swout_i),
        .fetch_miss_i (fetch_miss_i),
        .fault_i      (fault_i),
        .mem_op_i     (mem_op_i),
        .load_op_i    (load_op_i),
        .mem_miss_i   (mem_miss_i),
        .fill_done_i  (fill_done_i),
        .state_o      (st),
        .fetch_vld_o  (fetch_vld_o),
        .exec_o       (exec_o),
        .use_held_o   (use_held),
        .trap_o       (trap_o),
        .retire_o     (retire),
        .load_ret_o   (load_ret),
        .imiss_o      (imiss),
        .dmiss_o      (dmiss),
        .idone_o      (idone),
        .ddone_o      (ddone),
        .err_o        (err_o)
    );

    stseq_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance_i    (retire),
        .capture_i    (imiss),
        .use_held_i   (use_held),
        .insn_i       (insn_i),
        .pc_o         (pc_o),
        .npc_o        (npc_o),
        .fetch_addr_o (fetch_addr_o),
        .opcode_o     (opcode_o),
        .ra_o         (ra_o)
    );

    stseq_perf #(.CNT_W(CNT_W)) u_perf (
        .clk        (clk),
        .rst_n      (rst_n),
        .imiss_i    (imiss),
        .dmiss_i    (dmiss),
        .idone_i    (idone),
        .ddone_i    (ddone),
        .retire_i   (retire),
        .load_ret_i (load_ret),
        .ifill_o    (ifill_cyc_o),
        .dfill_o    (dfill_cyc_o),
        .retired_o  (retired_o),
        .loads_o    (loads_o)
    );

    assign fetch_size_o = 3'(INSN_BYTES);
    assign seq_state_o  = st;
endmodule

// File: rtl/stseq_chk.sv
module stseq_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_i,
    input logic             swout_i,
    input logic             fetch_miss_i,
    input logic             fetch_vld_o,
    input logic [AW-1:0]    fetch_addr_o,
    input logic [2:0]       fetch_size_o,
    input logic             exec_o,
    input logic             trap_o,
    input logic [AW-1:0]    pc_o,
    input logic [AW-1:0]    npc_o,
    input logic [CNT_W-1:0] retired_o,
    input logic [2:0]       seq_state_o,
    input logic             err_o
);
    // R3
    fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld_o |-> (fetch_addr_o[1:0] == 2'b00) && (fetch_size_o == 3'd4));
    // R3
    fetch_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld_o |-> (seq_state_o == 3'd1));
    // R4
    imiss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld_o && fetch_miss_i) |=> (seq_state_o == 3'd2));
    // R5
    resume_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state_o == 3'd3) && !swout_i) |-> (exec_o && !fetch_vld_o));
    // R7
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 3'd5) |=> (seq_state_o == 3'd5));
    // R7
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 3'd5) |-> (!fetch_vld_o && !exec_o));
    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (pc_o == $past(pc_o)) && (npc_o == $past(npc_o)));
    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !trap_o) |=> (pc_o == $past(npc_o)));
    // R11
    retire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_o && !trap_o) |=> $stable(retired_o));
    // R10
    bad_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && (seq_state_o != 3'd0)) |=> err_o);
endmodule

bind stall_sequencer stseq_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (act_i),
    .swout_i      (swout_i),
    .fetch_miss_i (fetch_miss_i),
    .fetch_vld_o  (fetch_vld_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_size_o (fetch_size_o),
    .exec_o       (exec_o),
    .trap_o       (trap_o),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .retired_o    (retired_o),
    .seq_state_o  (seq_state_o),
    .err_o        (err_o)
);

// File: tb/sim_stall_sequencer.sv
`timescale 1ns/1ps
module sim_stall_sequencer;
    localparam logic [31:0] RPC = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic act_i = 0, susp_i = 0, swout_i = 0, fetch_miss_i = 0;
    logic [31:0] insn_i = '0;
    logic fault_i = 0, mem_op_i = 0, load_op_i = 0, mem_miss_i = 0, fill_done_i = 0;
    logic fetch_vld_o, exec_o, trap_o, err_o;
    logic [31:0] fetch_addr_o, pc_o, npc_o;
    logic [2:0] fetch_size_o, seq_state_o;
    logic [5:0] opcode_o;
    logic [4:0] ra_o;
    logic [31:0] ifill_cyc_o, dfill_cyc_o, retired_o, loads_o;

    stall_sequencer u0 (.*);

    int total = 0;
    int bad = 0;

    // stimulus for the next cycle
    logic d_act, d_susp, d_sw, d_im, d_flt, d_mop, d_ld, d_dm, d_done;
    logic [31:0] d_insn;

    // reference model state
    int m_st;
    logic [31:0] m_pc, m_npc, m_held, m_if, m_df, m_ret, m_ld, m_cyc, m_mark;
    logic m_err;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        d_act = 0; d_susp = 0; d_sw = 0; d_im = 0; d_flt = 0;
        d_mop = 0; d_ld = 0; d_dm = 0; d_done = 0;
    endtask

    task automatic model_reset();
        m_st = 0; m_pc = RPC; m_npc = RPC + 4; m_held = 0;
        m_if = 0; m_df = 0; m_ret = 0; m_ld = 0; m_cyc = 0; m_mark = 0; m_err = 0;
    endtask

    // one clock: drive, compare every output with the model, advance the model
    task automatic step();
        logic fv, ex;
        logic [31:0] w;
        int nst;
        @(negedge clk);
        act_i = d_act; susp_i = d_susp; swout_i = d_sw; fetch_miss_i = d_im;
        insn_i = d_insn; fault_i = d_flt; mem_op_i = d_mop; load_op_i = d_ld;
        mem_miss_i = d_dm; fill_done_i = d_done;
        #1;
        fv = (m_st == 1) && !d_sw && !d_susp;
        ex = (fv && !d_im) || (m_st == 3 && !d_sw);
        w  = (m_st == 3) ? m_held : d_insn;
        chk("R2", "state", 32'(seq_state_o), 32'(m_st));
        chk("R3", "fetch_vld", 32'(fetch_vld_o), 32'(fv));
        if (fv) begin
            chk("R3", "fetch_addr", fetch_addr_o, {m_pc[31:2], 2'b00});
            chk("R3", "fetch_size", 32'(fetch_size_o), 32'd4);
        end
        chk("R5", "exec", 32'(exec_o), 32'(ex));
        chk("R8", "trap", 32'(trap_o), 32'(ex && d_flt));
        if (ex) begin
            chk("R9", "opcode", 32'(opcode_o), 32'(w >> 26));
            chk("R9", "ra", 32'(ra_o), 32'((w >> 21) & 32'h1f));
        end
        chk("R8", "pc", pc_o, m_pc);
        chk("R8", "npc", npc_o, m_npc);
        chk("R4", "ifill", ifill_cyc_o, m_if);
        chk("R6", "dfill", dfill_cyc_o, m_df);
        chk("R11", "retired", retired_o, m_ret);
        chk("R11", "loads", loads_o, m_ld);
        chk("R10", "err", 32'(err_o), 32'(m_err));
        // next model state
        m_err = (d_act && m_st != 0) || (d_susp && m_st != 1) ||
                (d_done && !(m_st == 2 || m_st == 4 || m_st == 5));
        nst = m_st;
        if (m_st == 0 && d_act) nst = 1;
        if (m_st == 1 && d_susp) nst = 0;
        else if (fv && d_im) begin nst = 2; m_mark = m_cyc; m_held = d_insn; end
        if (m_st == 3) nst = 1;
        if (ex && !d_flt) begin
            m_pc = m_npc; m_npc = m_npc + 4; m_ret = m_ret + 1;
            if (d_ld) m_ld = m_ld + 1;
            if (d_mop && d_dm) begin nst = 4; m_mark = m_cyc; end
        end
        if (m_st == 2 && d_done && !d_sw) begin m_if = m_if + (m_cyc - m_mark); nst = 3; end
        if (m_st == 4 && d_done && !d_sw) begin m_df = m_df + (m_cyc - m_mark); nst = 1; end
        if (d_sw) nst = 5;
        m_st = nst;
        m_cyc = m_cyc + 1;
        @(posedge clk);
        clr();
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr();
        d_insn = 32'h0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "state", 32'(seq_state_o), 32'd0);
        chk("R1", "pc", pc_o, RPC);
        chk("R1", "npc", npc_o, RPC + 4);
        chk("R1", "counters", ifill_cyc_o | dfill_cyc_o | retired_o | loads_o, 32'd0);
        chk("R1", "fetch_exec", 32'({fetch_vld_o, exec_o}), 32'd0);
        @(posedge clk);

        // R10: suspend and completion while idle
        d_susp = 1; step();
        d_done = 1; step();
        // R2: activate
        d_act = 1; step();
        // hits with several words, one load
        d_insn = 32'hFC00_0000; step();
        d_insn = 32'h03E0_1234; d_mop = 1; d_ld = 1; step();
        d_insn = 32'hA5A5_5A5A; step();
        // R8: fault
        d_insn = 32'h1234_5678; d_flt = 1; d_ld = 1; step();
        // R4/R5: fetch miss, completion after 3 cycles, resume
        d_insn = 32'h8C41_0004; d_im = 1; step();
        d_insn = 32'hFFFF_FFFF; step();
        d_act = 1; step();              // R10 activate outside idle
        d_done = 1; step();
        d_insn = 32'h0000_0000; step(); // resume executes held word
        // R6: data miss, wait 5 cycles
        d_insn = 32'h2C60_0010; d_mop = 1; d_dm = 1; step();
        idle_n(4);
        d_done = 1; step();
        idle_n(2);
        // R5: resume that itself data-misses
        d_insn = 32'h5555_0000; d_im = 1; step();
        d_done = 1; step();
        d_mop = 1; d_dm = 1; d_ld = 1; step();
        d_done = 1; step();
        // R10: completion in running
        d_insn = 32'h4000_0000; d_done = 1; step();
        // R2: suspend and reactivate
        d_susp = 1; step();
        idle_n(2);
        d_act = 1; step();
        // mixed random traffic without switch-out
        for (int k = 0; k < 400; k++) begin
            d_insn = $urandom;
            d_im   = ($urandom % 5) == 0;
            d_flt  = ($urandom % 9) == 0;
            d_mop  = ($urandom % 3) == 0;
            d_ld   = d_mop && $urandom % 2 == 1;
            d_dm   = d_mop && ($urandom % 4) == 0;
            d_done = ($urandom % 4) == 0;
            d_act  = ($urandom % 23) == 0;
            d_susp = ($urandom % 29) == 0;
            step();
        end
        // R7: switch-out during an instruction stall, late completion dropped
        d_act = 1; step();
        d_susp = 0; d_insn = 32'h1111_1111; d_im = 1; step();
        idle_n(1);
        if (seq_state_o == 3'd2) begin
            d_sw = 1; step();
        end else begin
            d_sw = 1; step();
        end
        begin
            logic [31:0] keep_if;
            keep_if = ifill_cyc_o;
            d_done = 1; step();
            d_done = 1; d_act = 1; step();
            #2;
            chk("R7", "parked_state", 32'(seq_state_o), 32'd5);
            chk("R7", "ifill_unchanged", ifill_cyc_o, keep_if);
        end
        idle_n(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule